// File: doc/BRIEF.md
# Miss Status Holding Register File

This block tracks the line misses of a non-blocking cache. Each distinct line that is being fetched from memory owns one entry. The entry keeps the line address, the register tags of every load waiting on that line, and the fill data as it arrives. While fills are pending, the cache keeps answering hits on other lines. Further misses are merged into the entry of a line already in flight, so no second memory request goes out. The pipeline is held only when a miss cannot be recorded.

A miss arrives on a valid/ready stream. `miss_ready` is computed in the same cycle from the offered line, and `stall` is the pipeline hold, raised only while a miss is offered and refused. A refused miss must be held until it is accepted. Memory requests leave on a second valid/ready stream. A request stays stable while `req_ready` is low and is removed in the cycle after it is taken. Fill chunks come back tagged with the entry id and have no back-pressure. The block accepts one chunk per cycle.

When the last chunk of a line arrives, the block presents the whole line and its target list on the completion outputs in that same cycle. The entry is then freed. The number of entries is a parameter, so that it can be sized to the bus bandwidth.

Top module: `mshr_file`

## Requirements
- R1: A miss to a line held by no live entry, offered while an entry is free, is accepted. The lowest-numbered free entry is allocated, and a memory request carrying that line and entry id is valid on the next cycle.
- R2: A miss whose line matches a live entry is merged into it. Its register tag is added to that entry's target list and no new memory request is made. The list holds N_TGT tags including the primary one (4 by default).
- R3: `miss_ready` is low only in two cases: a new line is offered and every entry is busy, or a matching entry already holds N_TGT targets. `stall` equals `miss_valid` with `miss_ready` low.
- R4: A miss to a line already in flight is accepted while every entry is busy, provided its target list has room.
- R5: At most one request is issued per cycle, in entry-allocation order. A request is held with stable line and id while `req_ready` is low.
- R6: A line fill is CHUNKS chunks (4 by default) on `fill_valid`/`fill_id`, in any spacing. `done_valid` is high only in the cycle of the last chunk. In that cycle `done_data` holds chunk k at bits [k*DATA_W +: DATA_W], and `done_tgts` holds slot k at bits [k*TAG_W +: TAG_W] in arrival order, with `done_tgt_cnt` giving the count.
- R7: A completing entry is free from the next cycle. A later miss to the same line is then a new primary miss.
- R8: A miss to the line that completes in the same cycle is accepted as a hit on the returning data. `done_byp_vld` goes high with its tag on `done_byp_tgt`, and no entry is allocated or merged.
- R9: After reset no entry is live, no request or completion is valid, and a miss is accepted.
- R10: The block works with N_ENT of 2 as well as 4. With 2 entries, a third distinct line stalls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_valid | input | 1 | Miss offered |
| miss_ready | output | 1 | Miss can be accepted this cycle |
| miss_line | input | LINE_W | Line address of the miss |
| miss_tag | input | TAG_W | Destination register tag |
| stall | output | 1 | Pipeline hold: miss offered and refused |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory side takes the request |
| req_line | output | LINE_W | Requested line address |
| req_id | output | ID_W | Entry id the fill must carry |
| fill_valid | input | 1 | Fill chunk valid |
| fill_id | input | ID_W | Entry the chunk belongs to |
| fill_data | input | DATA_W | Chunk data |
| done_valid | output | 1 | Line complete this cycle |
| done_id | output | ID_W | Completing entry |
| done_line | output | LINE_W | Completing line address |
| done_tgt_cnt | output | NT_W | Number of recorded targets |
| done_tgts | output | N_TGT*TAG_W | Recorded target tags |
| done_data | output | CHUNKS*DATA_W | Whole line |
| done_byp_vld | output | 1 | Same-cycle miss served by the completing line |
| done_byp_tgt | output | TAG_W | Tag of that miss |

## Verification
`miss_ready`, `stall` and every completion output are combinational on the current inputs and state, so they are due in the cycle the stimulus is driven. The bench drives on the falling edge and samples them 1 ns later, before the next rising edge. A new request and the freeing of an entry take effect at the rising edge after acceptance or completion. The bench therefore checks `req_valid`, `req_line`, the issue order and entry reuse on the falling edge that follows, one cycle on. A second instance with two entries checks the smaller configuration.

// File: rtl/mshr_pkg.sv
package mshr_pkg;
  typedef enum logic [2:0] {
    MK_NONE   = 3'd0,
    MK_ALLOC  = 3'd1,
    MK_MERGE  = 3'd2,
    MK_BYPASS = 3'd3,
    MK_STALL  = 3'd4
  } miss_kind_e;
endpackage

// File: rtl/mshr_lookup.sv
module mshr_lookup #(
  parameter int N_ENT  = 4,
  parameter int LINE_W = 26,
  parameter int ID_W   = 2
) (
  input  logic [N_ENT-1:0]        ent_vld,
  input  logic [N_ENT*LINE_W-1:0] ent_lines,
  input  logic [LINE_W-1:0]       key,
  output logic                    hit,
  output logic [ID_W-1:0]         hit_id,
  output logic                    free_any,
  output logic [ID_W-1:0]         free_id
);
  logic [N_ENT-1:0] match;

  for (genvar e = 0; e < N_ENT; e++) begin : g_cmp
    assign match[e] = ent_vld[e] && (ent_lines[e*LINE_W +: LINE_W] == key);
  end

  // lowest index wins for both encoders
  always_comb begin
    hit      = |match;
    free_any = ~&ent_vld;
    hit_id   = '0;
    free_id  = '0;
    for (int e = N_ENT - 1; e >= 0; e--) begin
      if (match[e])    hit_id  = ID_W'(e);
      if (!ent_vld[e]) free_id = ID_W'(e);
    end
  end
endmodule

// File: rtl/mshr_issue_q.sv
module mshr_issue_q #(
  parameter int N_ENT = 4,
  parameter int ID_W  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  logic [ID_W-1:0] push_id,
  input  logic            pop,
  output logic            out_vld,
  output logic [ID_W-1:0] out_id
);
  localparam int CW = $clog2(N_ENT + 1);

  logic [ID_W-1:0] slot [N_ENT];
  logic [ID_W-1:0] wr_p, rd_p;
  logic [CW-1:0]   cnt;

  function automatic logic [ID_W-1:0] nxt(input logic [ID_W-1:0] p);
    return (p == ID_W'(N_ENT - 1)) ? '0 : p + ID_W'(1);
  endfunction

  assign out_vld = (cnt != '0);
  assign out_id  = slot[rd_p];

  // each entry sits in the queue at most once, so it never overflows
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_p <= '0;
      rd_p <= '0;
      cnt  <= '0;
    end else begin
      if (push) begin
        slot[wr_p] <= push_id;
        wr_p       <= nxt(wr_p);
      end
      if (pop) rd_p <= nxt(rd_p);
      if (push && !pop)      cnt <= cnt + CW'(1);
      else if (!push && pop) cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/mshr_file.sv
module mshr_file
  import mshr_pkg::*;
#(
  parameter int N_ENT  = 4,
  parameter int LINE_W = 26,
  parameter int TAG_W  = 6,
  parameter int N_TGT  = 4,
  parameter int CHUNKS = 4,
  parameter int DATA_W = 64,
  localparam int ID_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
  localparam int NT_W  = $clog2(N_TGT + 1),
  localparam int CNT_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     miss_valid,
  output logic                     miss_ready,
  input  logic [LINE_W-1:0]        miss_line,
  input  logic [TAG_W-1:0]         miss_tag,
  output logic                     stall,
  output logic                     req_valid,
  input  logic                     req_ready,
  output logic [LINE_W-1:0]        req_line,
  output logic [ID_W-1:0]          req_id,
  input  logic                     fill_valid,
  input  logic [ID_W-1:0]          fill_id,
  input  logic [DATA_W-1:0]        fill_data,
  output logic                     done_valid,
  output logic [ID_W-1:0]          done_id,
  output logic [LINE_W-1:0]        done_line,
  output logic [NT_W-1:0]          done_tgt_cnt,
  output logic [N_TGT*TAG_W-1:0]   done_tgts,
  output logic [CHUNKS*DATA_W-1:0] done_data,
  output logic                     done_byp_vld,
  output logic [TAG_W-1:0]         done_byp_tgt
);
  logic [N_ENT-1:0]  ent_vld;
  logic [LINE_W-1:0] ent_line [N_ENT];
  logic [CNT_W-1:0]  ent_cnt  [N_ENT];
  logic [NT_W-1:0]   ent_ntgt [N_ENT];
  logic [TAG_W-1:0]  ent_tgt  [N_ENT][N_TGT];
  logic [DATA_W-1:0] ent_data [N_ENT][CHUNKS-1];

  logic [N_ENT*LINE_W-1:0] lines_flat;
  logic                    hit, free_any;
  logic [ID_W-1:0]         hit_id, free_id;
  logic                    completing, alloc, merge, pop, q_vld;
  logic [ID_W-1:0]         q_id;
  miss_kind_e              kind_raw, kind;

  for (genvar e = 0; e < N_ENT; e++) begin : g_flat
    assign lines_flat[e*LINE_W +: LINE_W] = ent_line[e];
  end

  mshr_lookup #(.N_ENT(N_ENT), .LINE_W(LINE_W), .ID_W(ID_W)) u_lookup (
    .ent_vld  (ent_vld),
    .ent_lines(lines_flat),
    .key      (miss_line),
    .hit      (hit),
    .hit_id   (hit_id),
    .free_any (free_any),
    .free_id  (free_id)
  );

  assign completing = fill_valid && ent_vld[fill_id] &&
                      (ent_cnt[fill_id] == CNT_W'(CHUNKS - 1));

  // classify the offered line; a refusal here is the only source of stall
  always_comb begin
    if (hit && completing && (hit_id == fill_id)) kind_raw = MK_BYPASS;
    else if (hit)      kind_raw = (ent_ntgt[hit_id] < NT_W'(N_TGT)) ? MK_MERGE : MK_STALL;
    else if (free_any) kind_raw = MK_ALLOC;
    else               kind_raw = MK_STALL;
    kind = miss_valid ? kind_raw : MK_NONE;
  end

  assign miss_ready = (kind_raw != MK_STALL);
  assign stall      = miss_valid && !miss_ready;
  assign alloc      = (kind == MK_ALLOC);
  assign merge      = (kind == MK_MERGE);

  mshr_issue_q #(.N_ENT(N_ENT), .ID_W(ID_W)) u_issue (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (alloc),
    .push_id(free_id),
    .pop    (pop),
    .out_vld(q_vld),
    .out_id (q_id)
  );

  assign req_valid = q_vld;
  assign req_id    = q_id;
  assign req_line  = ent_line[q_id];
  assign pop       = q_vld && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      for (int e = 0; e < N_ENT; e++) begin
        ent_cnt[e]  <= '0;
        ent_ntgt[e] <= '0;
      end
    end else begin
      for (int e = 0; e < N_ENT; e++) begin
        if (alloc && free_id == ID_W'(e)) begin
          ent_vld[e]    <= 1'b1;
          ent_line[e]   <= miss_line;
          ent_cnt[e]    <= '0;
          ent_ntgt[e]   <= NT_W'(1);
          ent_tgt[e][0] <= miss_tag;
        end
        if (merge && hit_id == ID_W'(e)) begin
          for (int s = 0; s < N_TGT; s++)
            if (ent_ntgt[e] == NT_W'(s)) ent_tgt[e][s] <= miss_tag;
          ent_ntgt[e] <= ent_ntgt[e] + NT_W'(1);
        end
        if (fill_valid && ent_vld[e] && fill_id == ID_W'(e)) begin
          if (completing) begin
            ent_vld[e] <= 1'b0;
          end else begin
            for (int c = 0; c < CHUNKS - 1; c++)
              if (ent_cnt[e] == CNT_W'(c)) ent_data[e][c] <= fill_data;
            ent_cnt[e] <= ent_cnt[e] + CNT_W'(1);
          end
        end
      end
    end
  end

  assign done_valid   = completing;
  assign done_id      = fill_id;
  assign done_line    = ent_line[fill_id];
  assign done_tgt_cnt = ent_ntgt[fill_id];
  assign done_byp_vld = (kind == MK_BYPASS);
  assign done_byp_tgt = miss_tag;

  for (genvar s = 0; s < N_TGT; s++) begin : g_tgt
    assign done_tgts[s*TAG_W +: TAG_W] = ent_tgt[fill_id][s];
  end
  for (genvar c = 0; c < CHUNKS - 1; c++) begin : g_dat
    assign done_data[c*DATA_W +: DATA_W] = ent_data[fill_id][c];
  end
  assign done_data[(CHUNKS-1)*DATA_W +: DATA_W] = fill_data;
endmodule

// File: rtl/mshr_file_chk.sv
module mshr_file_chk #(
  parameter int N_ENT  = 4,
  parameter int LINE_W = 26,
  localparam int ID_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              miss_ready,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LINE_W-1:0] req_line,
  input logic [ID_W-1:0]   req_id,
  input logic              fill_valid,
  input logic              done_valid,
  input logic [ID_W-1:0]   done_id,
  input logic [N_ENT-1:0]  ent_vld,
  input logic              alloc
);
  a_r1_alloc_then_req: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |=> req_valid);

  a_r3_ready_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_vld == '0) |-> miss_ready);

  a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line) && $stable(req_id)));

  a_r6_done_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> (fill_valid && ent_vld[done_id]));

  a_r7_free_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !ent_vld[$past(done_id)]);
endmodule

bind mshr_file mshr_file_chk #(.N_ENT(N_ENT), .LINE_W(LINE_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .miss_ready(miss_ready),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_line  (req_line),
  .req_id    (req_id),
  .fill_valid(fill_valid),
  .done_valid(done_valid),
  .done_id   (done_id),
  .ent_vld   (ent_vld),
  .alloc     (alloc)
);

// File: tb/mshr_file_tb.sv
module mshr_file_tb;
  localparam int LW = 26, TW = 6, DW = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic          miss_valid, miss_ready, stall, req_valid, req_ready;
  logic [LW-1:0] miss_line, req_line, done_line;
  logic [TW-1:0] miss_tag, done_byp_tgt;
  logic [1:0]    req_id, fill_id, done_id;
  logic          fill_valid, done_valid, done_byp_vld;
  logic [DW-1:0] fill_data;
  logic [2:0]    done_tgt_cnt;
  logic [4*TW-1:0] done_tgts;
  logic [4*DW-1:0] done_data;

  mshr_file u_dut (.*);

  logic          m2_valid, m2_ready, m2_stall, r2_valid, d2_valid, d2_byp;
  logic [LW-1:0] m2_line, r2_line, d2_line;
  logic [TW-1:0] d2_byp_tgt;
  logic          r2_id, d2_id;
  logic [2:0]    d2_cnt;
  logic [4*TW-1:0] d2_tgts;
  logic [4*DW-1:0] d2_data;

  mshr_file #(.N_ENT(2)) u_dut2 (
    .clk(clk), .rst_n(rst_n), .miss_valid(m2_valid), .miss_ready(m2_ready),
    .miss_line(m2_line), .miss_tag(6'd0), .stall(m2_stall), .req_valid(r2_valid),
    .req_ready(1'b0), .req_line(r2_line), .req_id(r2_id), .fill_valid(1'b0),
    .fill_id(1'b0), .fill_data('0), .done_valid(d2_valid), .done_id(d2_id),
    .done_line(d2_line), .done_tgt_cnt(d2_cnt), .done_tgts(d2_tgts),
    .done_data(d2_data), .done_byp_vld(d2_byp), .done_byp_tgt(d2_byp_tgt));

  int checks = 0, errors = 0;
  bit finished = 0;

  localparam logic [LW-1:0] LA = 26'h100, LB = 26'h200, LC = 26'h300,
                            LD = 26'h400, LE = 26'h500;

  task automatic chk(input string rq, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  // drive on falling edge, let comb settle
  task automatic offer(input logic [LW-1:0] l, input logic [TW-1:0] t);
    @(negedge clk);
    miss_valid = 1'b1; miss_line = l; miss_tag = t;
    #1;
  endtask

  task automatic idle_miss();
    @(negedge clk);
    miss_valid = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    chk("R9 miss_ready", miss_ready, 1);
    chk("R9 stall", stall, 0);
    chk("R9 req_valid", req_valid, 0);
    chk("R9 done_valid", done_valid, 0);
  endtask

  task automatic t_primary();
    req_ready = 1'b0;
    offer(LA, 6'd1);
    chk("R1 accept primary", {miss_ready, stall}, 2'b10);
    idle_miss();
    chk("R1 req_valid", req_valid, 1);
    chk("R1 req_line", req_line, LA);
    chk("R1 req_id", req_id, 0);
  endtask

  task automatic t_merge();
    for (int k = 2; k <= 4; k++) begin
      offer(LA, TW'(k));
      chk("R2 merge accepted", miss_ready, 1);
    end
    offer(LA, 6'd5);
    chk("R3 full target list stalls", {miss_ready, stall}, 2'b01);
    idle_miss();
    chk("R5 request held", {req_valid, req_line, req_id}, {1'b1, LA, 2'd0});
  endtask

  task automatic t_full();
    offer(LB, 6'd10); chk("R1 alloc B", miss_ready, 1);
    offer(LC, 6'd11); chk("R1 alloc C", miss_ready, 1);
    offer(LD, 6'd12); chk("R1 alloc D", miss_ready, 1);
    offer(LE, 6'd13);
    chk("R3 all entries busy stalls", {miss_ready, stall}, 2'b01);
    offer(LB, 6'd14);
    chk("R4 merge while full", {miss_ready, stall}, 2'b10);
    idle_miss();
  endtask

  task automatic t_issue();
    logic [LW-1:0] exp_l [4] = '{LA, LB, LC, LD};
    req_ready = 1'b1;
    for (int k = 0; k < 4; k++) begin
      chk("R5 issue order", {req_valid, req_line, req_id}, {1'b1, exp_l[k], 2'(k)});
      @(negedge clk); #1;
    end
    chk("R2 R5 no extra request", req_valid, 0);
  endtask

  task automatic t_fill();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      fill_valid = 1'b1; fill_id = 2'd0; fill_data = 64'hA000 + DW'(k);
      #1;
      if (k < 3) chk("R6 no done before last chunk", done_valid, 0);
      else begin
        chk("R6 done on last chunk", {done_valid, done_id, done_line, done_tgt_cnt},
            {1'b1, 2'd0, LA, 3'd4});
        chk("R6 targets", done_tgts, {6'd4, 6'd3, 6'd2, 6'd1});
        chk("R6 line data", done_data,
            {64'hA003, 64'hA002, 64'hA001, 64'hA000});
      end
      @(negedge clk);
      fill_valid = 1'b0;
      #1;
      chk("R6 done only with chunk", done_valid, 0);
    end
    offer(LE, 6'd13);
    chk("R7 freed entry accepts new line", miss_ready, 1);
    idle_miss();
    chk("R7 reuse entry 0", {req_valid, req_line, req_id}, {1'b1, LE, 2'd0});
  endtask

  task automatic t_bypass();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      fill_valid = 1'b1; fill_id = 2'd1; fill_data = 64'hB000 + DW'(k);
      if (k == 3) begin miss_valid = 1'b1; miss_line = LB; miss_tag = 6'd20; end
      #1;
    end
    chk("R8 bypass accepted", {miss_ready, done_valid, done_byp_vld, done_byp_tgt},
        {3'b111, 6'd20});
    chk("R8 targets of B", {done_tgt_cnt, done_tgts[2*TW-1:0]}, {3'd2, 6'd14, 6'd10});
    @(negedge clk);
    fill_valid = 1'b0; miss_valid = 1'b0;
    #1;
    chk("R8 no allocation", req_valid, 0);
    offer(LB, 6'd21);
    chk("R7 line B new primary", miss_ready, 1);
    idle_miss();
    chk("R7 request for B", {req_valid, req_line}, {1'b1, LB});
  endtask

  task automatic t_small();
    @(negedge clk); m2_valid = 1'b1; m2_line = LA; #1;
    chk("R10 first entry", m2_ready, 1);
    @(negedge clk); m2_line = LB; #1;
    chk("R10 second entry", m2_ready, 1);
    @(negedge clk); m2_line = LC; #1;
    chk("R10 third line stalls", {m2_ready, m2_stall}, 2'b01);
    @(negedge clk); m2_valid = 1'b0; #1;
    chk("R10 first request", {r2_valid, r2_line, r2_id}, {1'b1, LA, 1'b0});
  endtask

  initial begin
    miss_valid = 0; miss_line = '0; miss_tag = '0; req_ready = 0;
    fill_valid = 0; fill_id = '0; fill_data = '0;
    m2_valid = 0; m2_line = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_primary();
    t_merge();
    t_full();
    t_issue();
    t_fill();
    t_bypass();
    t_small();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R9 watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule